// File: doc/BRIEF.md
# Remote DMA Byte-Transfer Engine

The engine copies data between a host-side data port and a local packet memory. Software programs a 16-bit start address and a 16-bit byte count, each as a low and a high byte register. It then writes a 3-bit command that starts a read (memory to host) or a write (host to memory). Each memory access is a single request that stays asserted until the memory arbiter grants it. Each access moves either one byte or one 16-bit word, chosen by a configuration bit. A second configuration bit sets which host byte lane maps to the even memory address in word transfers.

While a transfer runs, the current address advances and the remaining count falls. Software can read both back at the offsets where it wrote them. When the count reaches zero, a completion flag is raised. An abort code stops the engine at once. It leaves the current address where the transfer stopped and does not raise the flag.

Register offsets (reg_addr): 0 address low, 1 address high, 2 count low, 3 count high, 4 configuration (bit 0 word mode, bit 1 swap), 5 command (bits 2:0), 6 status (bit 0 complete, write 1 to clear).

Top module: `rdma_engine`

## Requirements
- R1: After reset the current address, remaining count and complete flag read as zero, and neither mem_req nor dp_ready is asserted.
- R2: Writes at offsets 0/1 load the address low/high byte and at 2/3 the count low/high byte; reads at the same offsets return the current address and remaining count.
- R3: A byte-mode read (command 001, config bit 0 = 0) fetches the byte at the current address from lane addr[0] (0: mem_rdata[7:0], 1: mem_rdata[15:8]) and presents it on dp_rdata[7:0] with dp_rdata[15:8] zero; each access adds 1 to the address and subtracts 1 from the count.
- R4: A byte-mode write (command 010) writes host byte dp_wdata[7:0] to the current address, enabling only lane addr[0] on mem_be, which is never zero during a request.
- R5: In word mode (config bit 0 = 1) each access adds 2 to the address and moves two bytes with mem_be = 11; when one byte remains, the access enables only lane addr[0], carries host byte dp_wdata[7:0] (write) or returns the byte on dp_rdata[7:0] (read), and brings the count to zero.
- R6: In word mode with config bit 1 = 0, host bits [7:0] map to the even memory address; with bit 1 = 1, host bits [15:8] map to the even address.
- R7: When the count reaches zero the status bit (offset 6 bit 0) and done_flag are set; writing 1 to that bit, or starting a new transfer with a nonzero count, clears it.
- R8: Starting a read or write with a count of zero sets the complete flag on the next clock and issues no memory access.
- R9: Any command with bit 2 set is an abort, whatever bits 1:0 hold. It stops the transfer with no further memory request, keeps the current address and count where they stopped (the start address is not restored), empties the data holding register and leaves the complete flag clear.
- R10: Commands 000 and 011 are ignored: no memory access, and address, count and complete flag stay unchanged.
- R11: A memory request stays asserted with a stable address until mem_gnt, unless an abort or register write intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| dp_rd | input | 1 | Host data-port read strobe |
| dp_wr | input | 1 | Host data-port write strobe |
| dp_wdata | input | 16 | Host data-port write data |
| dp_rdata | output | 16 | Host data-port read data |
| dp_ready | output | 1 | Data available (read) or space available (write) |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Memory grant; access completes in a granted request cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address of access |
| mem_be | output | 2 | Byte-lane enables |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid in the grant cycle |
| cur_addr | output | 16 | Current remote address |
| done_flag | output | 1 | Transfer-complete flag |

## Verification
The assertions take for granted that word-mode transfers start at an even address. They also assume software does not rewrite the address or count while a request waits for a grant, and does not issue a command while a transfer is in flight other than an abort. The stimulus meets these conditions: it programs every register only while the engine is idle, places word transfers on even addresses, and aborts only once the engine is holding a fetched byte. The grant is stalled on alternate cycles in some tests, so that held requests occur.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
    localparam logic [2:0] OFS_ADDR_LO = 3'd0;
    localparam logic [2:0] OFS_ADDR_HI = 3'd1;
    localparam logic [2:0] OFS_CNT_LO  = 3'd2;
    localparam logic [2:0] OFS_CNT_HI  = 3'd3;
    localparam logic [2:0] OFS_CFG     = 3'd4;
    localparam logic [2:0] OFS_CMD     = 3'd5;
    localparam logic [2:0] OFS_STAT    = 3'd6;

    localparam logic [2:0] CMD_NONE = 3'b000;
    localparam logic [2:0] CMD_RD   = 3'b001;
    localparam logic [2:0] CMD_WR   = 3'b010;
    localparam logic [2:0] CMD_SEND = 3'b011;

    typedef enum logic {ST_IDLE, ST_BUSY} seq_st_e;

    typedef struct packed {
        logic [1:0] cfg;   // bit0 word mode, bit1 swap
        logic       done;
    } regs_t;

    typedef struct packed {
        logic       word;
        logic       swap;
        logic       go_rd;
        logic       go_wr;
        logic       abort;
        logic       nop;
        logic       ld_alo;
        logic       ld_ahi;
        logic       ld_clo;
        logic       ld_chi;
    } ctl_t;
endpackage

// File: rtl/rdma_regs.sv
module rdma_regs
    import rdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    input  logic [AW-1:0] cur_addr,
    input  logic [CW-1:0] cur_cnt,
    input  logic          fin,
    input  logic          launch,
    output ctl_t          ctl,
    output logic          done,
    output logic [7:0]    reg_rdata
);
    regs_t q, d;
    logic  wr_cmd;
    logic  clr_done;
    logic [15:0] a16;
    logic [15:0] c16;

    always_comb begin
        wr_cmd     = reg_wr && (reg_addr == OFS_CMD);
        clr_done   = reg_wr && (reg_addr == OFS_STAT) && reg_wdata[0];
        ctl.word   = q.cfg[0];
        ctl.swap   = q.cfg[1];
        ctl.abort  = wr_cmd && reg_wdata[2];
        ctl.go_rd  = wr_cmd && (reg_wdata[2:0] == CMD_RD);
        ctl.go_wr  = wr_cmd && (reg_wdata[2:0] == CMD_WR);
        ctl.nop    = wr_cmd && ((reg_wdata[2:0] == CMD_NONE) ||
                                (reg_wdata[2:0] == CMD_SEND));
        ctl.ld_alo = reg_wr && (reg_addr == OFS_ADDR_LO);
        ctl.ld_ahi = reg_wr && (reg_addr == OFS_ADDR_HI);
        ctl.ld_clo = reg_wr && (reg_addr == OFS_CNT_LO);
        ctl.ld_chi = reg_wr && (reg_addr == OFS_CNT_HI);
    end

    always_comb begin
        d = q;
        if (reg_wr && (reg_addr == OFS_CFG)) begin
            d.cfg = reg_wdata[1:0];
        end
        if (fin) begin
            d.done = 1'b1;
        end else if (clr_done || launch) begin
            d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done = q.done;

    always_comb begin
        a16 = 16'(cur_addr);
        c16 = 16'(cur_cnt);
        case (reg_addr)
            OFS_ADDR_LO: reg_rdata = a16[7:0];
            OFS_ADDR_HI: reg_rdata = a16[15:8];
            OFS_CNT_LO:  reg_rdata = c16[7:0];
            OFS_CNT_HI:  reg_rdata = c16[15:8];
            OFS_CFG:     reg_rdata = {6'b0, q.cfg};
            OFS_STAT:    reg_rdata = {7'b0, q.done};
            default:     reg_rdata = 8'h00;
        endcase
    end

    AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> done) else $error("done not set"); // R7
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !reg_wr) |=> done) else $error("done dropped"); // R7
endmodule

// File: rtl/rdma_lane.sv
module rdma_lane #(
    parameter int DW = 16,
    parameter int AW = 16
) (
    input  logic          rst_n,
    input  logic          req,
    input  logic          wide,
    input  logic          swap,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] hold,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW/8-1:0] be,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_host
);
    localparam int LANES = DW / 8;
    localparam int LSW   = (LANES > 1) ? $clog2(LANES) : 1;

    logic [LSW-1:0] lane_sel;
    logic [7:0]     sel_byte;

    assign lane_sel = LSW'(addr[LSW-1:0]);
    assign sel_byte = mem_rdata[lane_sel*8 +: 8];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int MIR = LANES - 1 - i;
        assign be[i] = wide || (lane_sel == LSW'(i));
        assign wdata[i*8 +: 8] = wide ? (swap ? hold[MIR*8 +: 8] : hold[i*8 +: 8])
                                      : hold[7:0];
        if (i == 0) begin : g_low
            assign rd_host[7:0] = wide ? (swap ? mem_rdata[MIR*8 +: 8] : mem_rdata[7:0])
                                       : sel_byte;
        end else begin : g_up
            assign rd_host[i*8 +: 8] = wide ? (swap ? mem_rdata[MIR*8 +: 8]
                                                    : mem_rdata[i*8 +: 8])
                                            : 8'h00;
        end
    end

    always_comb begin
        if (rst_n && req) begin
            AST_LANE_ENABLED: assert (be != '0) else $error("no lane enabled"); // R4
        end
    end
endmodule

// File: rtl/rdma_seq.sv
module rdma_seq
    import rdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctl_t          ctl,
    input  logic [7:0]    reg_wdata,
    input  logic          dp_rd,
    input  logic          dp_wr,
    input  logic [DW-1:0] dp_wdata,
    input  logic          mem_gnt,
    input  logic [DW-1:0] lane_rd,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] cnt,
    output logic [DW-1:0] hold,
    output logic          wide,
    output logic          dp_ready,
    output logic          fin,
    output logic          launch
);
    localparam logic [AW-1:0] ASTEP_B = AW'(1);
    localparam logic [AW-1:0] ASTEP_W = AW'(DW / 8);
    localparam logic [CW-1:0] CSTEP_B = CW'(1);
    localparam logic [CW-1:0] CSTEP_W = CW'(DW / 8);

    typedef struct packed {
        seq_st_e       st;
        logic          dir;      // 1 = host to memory
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
        logic [DW-1:0] hold;
        logic          hold_v;
    } seq_t;

    seq_t q, d;
    logic access;
    logic ld_any;
    logic [CW-1:0] cnt_nx;

    always_comb begin
        wide     = ctl.word && (q.cnt >= CSTEP_W);
        mem_req  = (q.st == ST_BUSY) && (q.dir ? q.hold_v : !q.hold_v) && !ctl.abort;
        access   = mem_req && mem_gnt;
        dp_ready = q.dir ? ((q.st == ST_BUSY) && !q.hold_v) : q.hold_v;
        ld_any   = ctl.ld_alo || ctl.ld_ahi || ctl.ld_clo || ctl.ld_chi;
        cnt_nx   = q.cnt - (wide ? CSTEP_W : CSTEP_B);
    end

    always_comb begin
        d      = q;
        fin    = 1'b0;
        launch = 1'b0;

        if (access) begin
            d.addr = q.addr + (ctl.word ? ASTEP_W : ASTEP_B);
            d.cnt  = cnt_nx;
            if (q.dir) begin
                d.hold_v = 1'b0;
            end else begin
                d.hold   = lane_rd;
                d.hold_v = 1'b1;
            end
            if (cnt_nx == '0) begin
                d.st = ST_IDLE;
                fin  = 1'b1;
            end
        end

        if (!q.dir && q.hold_v && dp_rd) begin
            d.hold_v = 1'b0;
        end
        if (q.dir && (q.st == ST_BUSY) && !q.hold_v && dp_wr) begin
            d.hold   = dp_wdata;
            d.hold_v = 1'b1;
        end

        if (ctl.ld_alo) d.addr[7:0]    = reg_wdata;
        if (ctl.ld_ahi) d.addr[AW-1:8] = reg_wdata[AW-9:0];
        if (ctl.ld_clo) d.cnt[7:0]     = reg_wdata;
        if (ctl.ld_chi) d.cnt[CW-1:8]  = reg_wdata[CW-9:0];

        if ((ctl.go_rd || ctl.go_wr) && (q.st == ST_IDLE)) begin
            d.dir    = ctl.go_wr;
            d.hold_v = 1'b0;
            if (q.cnt == '0) begin
                fin = 1'b1;
            end else begin
                d.st   = ST_BUSY;
                launch = 1'b1;
            end
        end

        if (ctl.abort) begin
            d.st     = ST_IDLE;
            d.hold_v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, dir: 1'b0, addr: '0, cnt: '0, hold: '0, hold_v: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign mem_we = q.dir;
    assign addr   = q.addr;
    assign cnt    = q.cnt;
    assign hold   = q.hold;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !ctl.abort) |=> mem_req) else $error("req dropped"); // R11
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !ctl.abort && !ld_any) |=> $stable(addr)) else $error("addr moved"); // R11
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.abort |=> !mem_req) else $error("req after abort"); // R9
    AST_NOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.nop && (q.st == ST_IDLE)) |=> !mem_req) else $error("nop started"); // R10
    AST_CNT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !ld_any) |=> (cnt < $past(cnt))) else $error("count not reduced"); // R3
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
    import rdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          dp_rd,
    input  logic          dp_wr,
    input  logic [DW-1:0] dp_wdata,
    output logic [DW-1:0] dp_rdata,
    output logic          dp_ready,
    output logic          mem_req,
    input  logic          mem_gnt,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW/8-1:0] mem_be,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] cur_addr,
    output logic          done_flag
);
    ctl_t          ctl;
    logic [CW-1:0] cnt;
    logic [DW-1:0] hold;
    logic [DW-1:0] lane_rd;
    logic          wide;
    logic          fin;
    logic          launch;

    rdma_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cur_addr(cur_addr), .cur_cnt(cnt),
        .fin(fin), .launch(launch), .ctl(ctl), .done(done_flag),
        .reg_rdata(reg_rdata)
    );

    rdma_seq #(.AW(AW), .CW(CW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .reg_wdata(reg_wdata),
        .dp_rd(dp_rd), .dp_wr(dp_wr), .dp_wdata(dp_wdata),
        .mem_gnt(mem_gnt), .lane_rd(lane_rd), .mem_req(mem_req),
        .mem_we(mem_we), .addr(cur_addr), .cnt(cnt), .hold(hold),
        .wide(wide), .dp_ready(dp_ready), .fin(fin), .launch(launch)
    );

    rdma_lane #(.DW(DW), .AW(AW)) u_lane (
        .rst_n(rst_n), .req(mem_req), .wide(wide), .swap(ctl.swap),
        .addr(cur_addr), .hold(hold), .mem_rdata(mem_rdata),
        .be(mem_be), .wdata(mem_wdata), .rd_host(lane_rd)
    );

    assign mem_addr = cur_addr;
    assign dp_rdata = hold;
endmodule

// File: tb/tb_rdma_engine.sv
module tb_rdma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        dp_rd = 1'b0;
    logic        dp_wr = 1'b0;
    logic [15:0] dp_wdata = 16'h0;
    logic [15:0] dp_rdata;
    logic        dp_ready;
    logic        mem_req, mem_gnt, mem_we;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_be;
    logic [15:0] cur_addr;
    logic        done_flag;

    logic [7:0]  m [256];
    logic        stall = 1'b0;
    logic        tick = 1'b0;
    int          acc = 0;
    int          total = 0;
    int          fails = 0;
    string       tag = "R1";
    logic [15:0] rdq [$];
    logic [33:0] wrq [$];

    always #5 clk = ~clk;

    rdma_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_rd(dp_rd),
        .dp_wr(dp_wr), .dp_wdata(dp_wdata), .dp_rdata(dp_rdata),
        .dp_ready(dp_ready), .mem_req(mem_req), .mem_gnt(mem_gnt),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cur_addr(cur_addr),
        .done_flag(done_flag)
    );

    assign mem_gnt   = !stall || tick;
    assign mem_rdata = {m[{mem_addr[7:1], 1'b1}], m[{mem_addr[7:1], 1'b0}]};

    always @(posedge clk) begin
        tick <= ~tick;
        if (rst_n && mem_req && mem_gnt) begin
            acc <= acc + 1;
            if (mem_we) begin
                if (mem_be[0]) m[{mem_addr[7:1], 1'b0}] = mem_wdata[7:0];
                if (mem_be[1]) m[{mem_addr[7:1], 1'b1}] = mem_wdata[15:8];
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compares design results against queued expectations
    always @(negedge clk) begin
        #1;
        if (dp_rd && dp_ready) begin
            if (rdq.size() == 0) chk(tag, {16'h0, dp_rdata}, 32'hDEAD);
            else chk(tag, {16'h0, dp_rdata}, {16'h0, rdq.pop_front()});
        end
        if (mem_req && mem_gnt && mem_we) begin
            logic [33:0] e;
            logic [15:0] mask;
            e = (wrq.size() == 0) ? 34'h3FFFFFFFF : wrq.pop_front();
            mask = {{8{e[17]}}, {8{e[16]}}};
            chk(tag, {mem_addr, 14'h0, mem_be}, {e[33:18], 14'h0, e[17:16]});
            chk(tag, {16'h0, mem_wdata & mask}, {16'h0, e[15:0] & mask});
        end
    end

    task automatic wreg(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic setup(input logic [15:0] a, input logic [15:0] c, input logic [1:0] cfg);
        wreg(3'd0, a[7:0]); wreg(3'd1, a[15:8]);
        wreg(3'd2, c[7:0]); wreg(3'd3, c[15:8]);
        wreg(3'd4, {6'b0, cfg});
    endtask

    task automatic host_rd();
        @(negedge clk);
        while (!dp_ready) @(negedge clk);
        dp_rd = 1'b1;
        @(negedge clk);
        dp_rd = 1'b0;
    endtask

    task automatic host_wr(input logic [15:0] v);
        @(negedge clk);
        while (!dp_ready) @(negedge clk);
        dp_wdata = v; dp_wr = 1'b1;
        @(negedge clk);
        dp_wr = 1'b0;
    endtask

    task automatic wait_done();
        while (!done_flag) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        logic [7:0] v;
        int a0;
        for (int i = 0; i < 256; i++) m[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        tag = "R1";
        rreg(3'd0, v); chk("R1", {24'h0, v}, 0);
        rreg(3'd2, v); chk("R1", {24'h0, v}, 0);
        rreg(3'd6, v); chk("R1", {24'h0, v}, 0);
        chk("R1", {30'h0, mem_req, dp_ready}, 0);

        // R2 register load and readback
        tag = "R2";
        setup(16'h1234, 16'h0105, 2'b00);
        rreg(3'd0, v); chk("R2", {24'h0, v}, 32'h34);
        rreg(3'd1, v); chk("R2", {24'h0, v}, 32'h12);
        rreg(3'd2, v); chk("R2", {24'h0, v}, 32'h05);
        rreg(3'd3, v); chk("R2", {24'h0, v}, 32'h01);

        // R10 ignored commands
        tag = "R10";
        wreg(3'd5, 8'h00);
        wreg(3'd5, 8'h03);
        repeat (5) @(negedge clk);
        chk("R10", acc, 0);
        rreg(3'd0, v); chk("R10", {24'h0, v}, 32'h34);
        rreg(3'd2, v); chk("R10", {24'h0, v}, 32'h05);
        rreg(3'd6, v); chk("R10", {24'h0, v}, 0);

        // R3 byte read from odd start, R7 completion
        tag = "R3";
        setup(16'h0011, 16'd5, 2'b00);
        for (int i = 0; i < 5; i++) rdq.push_back({8'h00, m[8'h11 + i]});
        wreg(3'd5, 8'h01);
        for (int i = 0; i < 5; i++) host_rd();
        wait_done();
        chk("R3", {16'h0, cur_addr}, 32'h0016);
        rreg(3'd2, v); chk("R3", {24'h0, v}, 0);
        rreg(3'd6, v); chk("R7", {24'h0, v}, 1);
        chk("R7", {31'h0, done_flag}, 1);
        wreg(3'd6, 8'h01);
        chk("R7", {31'h0, done_flag}, 0);

        // R4 byte write with stalled grants, R11
        tag = "R4";
        stall = 1'b1;
        setup(16'h0040, 16'd3, 2'b00);
        wrq.push_back({16'h0040, 2'b01, 16'h5A5A});
        wrq.push_back({16'h0041, 2'b10, 16'h6B6B});
        wrq.push_back({16'h0042, 2'b01, 16'h7C7C});
        wreg(3'd5, 8'h02);
        host_wr(16'hFF5A); host_wr(16'hFF6B); host_wr(16'hFF7C);
        wait_done();
        chk("R4", {24'h0, m[8'h40]}, 32'h5A);
        chk("R11", {24'h0, m[8'h41]}, 32'h6B);
        chk("R4", {24'h0, m[8'h42]}, 32'h7C);
        chk("R4", {24'h0, m[8'h43]}, {24'h0, 8'(8'h43 * 7 + 3)});
        stall = 1'b0;
        wreg(3'd6, 8'h01);

        // R5 word read, R6 byte order normal then swapped
        tag = "R5";
        setup(16'h0020, 16'd6, 2'b01);
        for (int i = 0; i < 3; i++) rdq.push_back({m[8'h21 + 2*i], m[8'h20 + 2*i]});
        wreg(3'd5, 8'h01);
        for (int i = 0; i < 3; i++) host_rd();
        wait_done();
        chk("R5", {16'h0, cur_addr}, 32'h0026);
        tag = "R6";
        setup(16'h0030, 16'd4, 2'b11);
        for (int i = 0; i < 2; i++) rdq.push_back({m[8'h30 + 2*i], m[8'h31 + 2*i]});
        wreg(3'd5, 8'h01);
        for (int i = 0; i < 2; i++) host_rd();
        wait_done();
        chk("R6", {16'h0, cur_addr}, 32'h0034);

        // R5 word write with odd count
        tag = "R5";
        setup(16'h0050, 16'd3, 2'b01);
        wrq.push_back({16'h0050, 2'b11, 16'hA1B2});
        wrq.push_back({16'h0052, 2'b01, 16'hC3C3});
        wreg(3'd5, 8'h02);
        host_wr(16'hA1B2); host_wr(16'h00C3);
        wait_done();
        chk("R5", {16'h0, cur_addr}, 32'h0054);
        rreg(3'd2, v); chk("R5", {24'h0, v}, 0);
        chk("R5", {16'h0, m[8'h51], m[8'h50]}, 32'hA1B2);
        chk("R5", {24'h0, m[8'h52]}, 32'hC3);
        wreg(3'd6, 8'h01);

        // R8 zero-count start
        tag = "R8";
        setup(16'h0070, 16'd0, 2'b00);
        a0 = acc;
        wreg(3'd5, 8'h02);
        chk("R8", {31'h0, done_flag}, 1);
        repeat (4) @(negedge clk);
        chk("R8", acc, a0);
        chk("R8", {31'h0, dp_ready}, 0);
        wreg(3'd6, 8'h01);

        // R9 abort mid-transfer, all command bits set
        tag = "R9";
        stall = 1'b1;
        setup(16'h0060, 16'd10, 2'b00);
        for (int i = 0; i < 3; i++) rdq.push_back({8'h00, m[8'h60 + i]});
        wreg(3'd5, 8'h01);
        for (int i = 0; i < 3; i++) host_rd();
        @(negedge clk);
        while (!dp_ready) @(negedge clk);
        a0 = acc;
        wreg(3'd5, 8'h07);
        repeat (8) @(negedge clk);
        chk("R9", acc, a0);
        chk("R9", {31'h0, mem_req}, 0);
        chk("R9", {31'h0, dp_ready}, 0);
        rreg(3'd0, v); chk("R9", {24'h0, v}, 32'h64);
        rreg(3'd2, v); chk("R9", {24'h0, v}, 32'h06);
        chk("R9", {31'h0, done_flag}, 0);
        stall = 1'b0;

        chk("R3", rdq.size(), 0);
        chk("R4", wrq.size(), 0);
        summary();
    end
endmodule